// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a down-counting interval timer with a small byte-wide host register port. Software writes a reload value one byte at a time, then writes a control byte that arms the counter. The counter takes the reload value and steps down once per selected tick. The tick comes either from every cycle of the system clock or from each rising transition of an alternate enable input. When the count runs out, the block emits a one-cycle terminal-count pulse and latches an interrupt flag.

Two behaviours set by the control byte shape how the timer is used. In single-shot mode the timer stops after one interval and clears its own run bit. In re-trigger mode it reloads by itself and produces a periodic pulse train. A host read of the control byte clears the pending interrupt, so an interrupt handler acknowledges the event by reading the control byte it would inspect anyway. The counter width is a parameter in multiples of eight bits, and the reload value takes one byte register for each eight bits.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control byte and both reload bytes read 0x00, and `irq` and `tc_pulse` are low.
- R2: Address 0 is the control byte, address 1 the reload low byte and address 2 the reload high byte. Each reload byte reads back what was last written. Address 3 reads 0x00. Reload bit 0 is low-byte bit 0 and reload bit 15 is high-byte bit 7.
- R3: The control bits are: bit 0 interrupt enable, bit 1 run, bit 2 mode (0 single-shot, 1 re-trigger), bit 3 tick source (0 system clock, 1 alternate input). Bits 7 to 4 ignore writes and read 0.
- R4: A control write with bit 1 set loads the reload value L. With the system-clock source, `tc_pulse` is first high in the L-th cycle after the write edge, where the cycle right after the write edge counts as 0.
- R5: In single-shot mode the counter halts after the terminal count, control bit 1 reads 0, and no further `tc_pulse` occurs until run is written again.
- R6: In re-trigger mode the counter reloads at the terminal count and `tc_pulse` repeats every L ticks. Control bit 1 stays 1, and with L = 1 and the system-clock source `tc_pulse` stays high every cycle.
- R7: A control write with bit 1 clear stops counting, so no `tc_pulse` follows. A later write with bit 1 set restarts from the full reload value.
- R8: A reload value of 0 counts 65536 ticks.
- R9: The terminal count sets an interrupt flag whether or not interrupts are enabled. `irq` is the flag ANDed with control bit 0, so setting the enable later exposes a pending flag.
- R10: A host read of address 0 clears the flag, so `irq` is low from the cycle after that read. Reads of other addresses leave the flag set.
- R11: With control bit 3 set, each low-to-high transition of `alt_tick_in` counts one tick. A level held high for many cycles still counts once, and system-clock cycles alone do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of address 0 clears the interrupt) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alt_tick_in | input | 1 | Alternate tick source; its rising transitions count |
| irq | output | 1 | Timer interrupt (flag AND enable) |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
A wrong count or a wrong reload shows at `tc_pulse` as a first pulse or a pulse spacing that differs from L. The bench measures that spacing to the exact cycle, across a sweep of small reload values and at both bit-position extremes. A stale run bit or a missed halt appears within one interval, either as an extra pulse or as a wrong control readback. A flag that sets or clears at the wrong time is visible on `irq` one cycle after the event, or one cycle after the read that should clear it. A broken edge detector on the alternate input shows as an early terminal pulse when a long high level is miscounted.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   localparam int CTL_BITS = 4;

   typedef struct packed {
      logic csel;   // tick source: 1 = alternate input rising edge
      logic mode;   // 1 = re-trigger, 0 = single-shot
      logic run;    // 1 = counting
      logic ie;     // interrupt enable
   } ctl_t;

endpackage

// File: rtl/ptmr_tick.sv
module ptmr_tick #(
   parameter int ALT_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csel,
   input  logic alt_in,
   output logic tick
);

   generate
      if (ALT_STAGES < 2) begin : g_bad_stages
         $error("ptmr_tick: ALT_STAGES must be at least 2");
      end
   endgenerate

   logic [ALT_STAGES-1:0] sh_q;
   logic                  alt_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[ALT_STAGES-2:0], alt_in};
   end

   assign alt_rise = sh_q[ALT_STAGES-2] & ~sh_q[ALT_STAGES-1];
   assign tick     = csel ? alt_rise : 1'b1;

   // R11: a rising transition can never be seen on two consecutive cycles
   a_r11_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      alt_rise |=> !alt_rise);

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             active,
   input  logic             retrig,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic             expire,
   output logic             tc
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = active && tick && (cnt_q == CNT_W'(1));
   assign expire = at_end && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tc    <= 1'b0;
      end else begin
         tc <= expire;
         if (load)
            cnt_q <= reload;
         else if (at_end)
            cnt_q <= retrig ? reload : '0;
         else if (active && tick)
            cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // R7: a stopped counter holds its value
   a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> $stable(cnt_q));

   // R6: re-trigger terminal count reloads the programmed value
   a_r6_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && retrig) |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   input  logic              expire,
   output ctl_t              ctl,
   output logic [CNT_W-1:0]  reload,
   output logic              load,
   output logic              flag,
   output logic [7:0]        rdata
);

   localparam int NBYTES = CNT_W / 8;

   generate
      if ((1 << ADDR_W) < NBYTES + 1) begin : g_bad_addr
         $error("ptmr_regs: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [7:0] byte_q [NBYTES];
   logic       ctl_wr;
   logic       ctl_rd;
   logic [7-CTL_BITS:0] wdata_unused;

   assign wdata_unused = wdata[7:CTL_BITS];
   assign ctl_wr = wr_en && (addr == '0);
   assign ctl_rd = rd_en && (addr == '0);
   assign load   = ctl_wr && wdata[1];

   genvar b;
   generate
      for (b = 0; b < NBYTES; b++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q[b] <= '0;
            else if (wr_en && (addr == ADDR_W'(b + 1)))
               byte_q[b] <= wdata;
         end
         assign reload[8*b +: 8] = byte_q[b];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl <= '0;
      else if (ctl_wr)
         ctl <= ctl_t'(wdata[CTL_BITS-1:0]);
      else if (expire && !ctl.mode)
         ctl.run <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (expire)
         flag <= 1'b1;
      else if (ctl_rd)
         flag <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (addr == '0)
         rdata = {{(8-CTL_BITS){1'b0}}, ctl};
      for (int i = 0; i < NBYTES; i++)
         if (addr == ADDR_W'(i + 1))
            rdata = byte_q[i];
   end

   // R5: single-shot expiry drops the run bit
   a_r5_single_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctl.mode && !ctl_wr) |=> !ctl.run);

   // R9: terminal count always latches the flag
   a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);

   // R10: control read clears the flag when no new event arrives
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd && !expire) |=> !flag);

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 2,
   parameter int ALT_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              alt_tick_in,
   output logic              irq,
   output logic              tc_pulse
);

   generate
      if ((CNT_W < 8) || (CNT_W % 8 != 0)) begin : g_bad_width
         $error("ptmr_top: CNT_W must be a positive multiple of 8");
      end
   endgenerate

   ctl_t             ctl;
   logic [CNT_W-1:0] reload;
   logic             load;
   logic             flag;
   logic             expire;
   logic             tick;

   ptmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (reg_addr),
      .wr_en  (reg_wr),
      .rd_en  (reg_rd),
      .wdata  (reg_wdata),
      .expire (expire),
      .ctl    (ctl),
      .reload (reload),
      .load   (load),
      .flag   (flag),
      .rdata  (reg_rdata)
   );

   ptmr_tick #(.ALT_STAGES(ALT_STAGES)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .csel   (ctl.csel),
      .alt_in (alt_tick_in),
      .tick   (tick)
   );

   ptmr_count #(.CNT_W(CNT_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .active (ctl.run),
      .retrig (ctl.mode),
      .tick   (tick),
      .reload (reload),
      .expire (expire),
      .tc     (tc_pulse)
   );

   assign irq = flag & ctl.ie;

   // R9: an enabled terminal pulse is accompanied by the interrupt
   a_r9_irq_follows_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse && ctl.ie) |-> irq);

   // R3: reserved control bits read as zero
   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == '0) |-> (reg_rdata[7:4] == 4'h0));

endmodule

// File: tb/ptmr_top_test.sv
`timescale 1ns/1ps
module ptmr_top_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       alt_tick_in = 1'b0;
   logic       irq;
   logic       tc_pulse;

   int checks = 0;
   int errors = 0;
   int tc_cnt = 0;

   always #10 clk = ~clk;

   ptmr_top uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .alt_tick_in(alt_tick_in), .irq(irq), .tc_pulse(tc_pulse)
   );

   always @(posedge clk) if (tc_pulse) tc_cnt <= tc_cnt + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // cycles from the write edge until tc_pulse is seen
   task automatic measure(output int n);
      n = 0;
      while (!tc_pulse && n < 70000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic alt_pulse(input int h);
      @(negedge clk);
      alt_tick_in = 1'b1;
      repeat (h) @(negedge clk);
      alt_tick_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(20 * 190000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n, snap;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 low", v, 0);
      rd(2'd2, v); chk("R1 high", v, 0);
      chk("R1 irq", irq, 0);
      chk("R1 tc", tc_pulse, 0);

      // R2 readback sweep
      for (int i = 0; i < 256; i++) begin
         wr(2'd1, 8'(i)); rd(2'd1, v); chk("R2 low readback", v, i);
         wr(2'd2, 8'(255 - i)); rd(2'd2, v); chk("R2 high readback", v, 255 - i);
      end
      rd(2'd3, v); chk("R2 addr3 zero", v, 0);

      // R3 reserved bits
      wr(2'd0, 8'hF0); rd(2'd0, v); chk("R3 reserved ignored", v, 0);
      wr(2'd0, 8'hFD); rd(2'd0, v); chk("R3 field readback", v, 8'h0D);
      wr(2'd0, 8'h00);

      // R4 / R5 single-shot sweep
      wr(2'd2, 8'h00);
      for (int l = 1; l <= 24; l++) begin
         wr(2'd1, 8'(l));
         wr(2'd0, 8'h02);
         measure(n);
         chk("R4 first pulse", n, l);
         @(negedge clk);
         chk("R5 pulse width", tc_pulse, 0);
         rd(2'd0, v); chk("R5 run cleared", v, 0);
         snap = tc_cnt;
         repeat (2 * l + 5) @(negedge clk);
         chk("R5 no further pulse", tc_cnt, snap);
      end

      // R2 bit positions via timing
      wr(2'd1, 8'h00); wr(2'd2, 8'h01); wr(2'd0, 8'h02);
      measure(n); chk("R2 bit8 weight", n, 256);
      wr(2'd2, 8'h80); wr(2'd0, 8'h02);
      measure(n); chk("R2 bit15 weight", n, 32768);

      // R8 zero load
      wr(2'd2, 8'h00); wr(2'd0, 8'h02);
      measure(n); chk("R8 zero counts 65536", n, 65536);

      // R6 re-trigger
      wr(2'd1, 8'd5); wr(2'd0, 8'h06);
      measure(n); chk("R6 first interval", n, 5);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); n = 1;
         while (!tc_pulse && n < 100) begin @(negedge clk); n++; end
         chk("R6 period", n, 5);
      end
      rd(2'd0, v); chk("R6 run stays", v, 8'h06);
      wr(2'd1, 8'd1); wr(2'd0, 8'h06);
      @(negedge clk);
      for (int k = 0; k < 10; k++) begin
         chk("R6 L1 continuous", tc_pulse, 1);
         @(negedge clk);
      end
      wr(2'd0, 8'h00);

      // R7 stop and restart
      wr(2'd1, 8'd50); wr(2'd0, 8'h02);
      repeat (20) @(negedge clk);
      wr(2'd0, 8'h00);
      snap = tc_cnt;
      repeat (100) @(negedge clk);
      chk("R7 stopped no pulse", tc_cnt, snap);
      rd(2'd0, v); chk("R7 run reads 0", v, 0);
      wr(2'd0, 8'h02);
      measure(n); chk("R7 restart full", n, 50);

      // R9 / R10 interrupt
      rd(2'd0, v);
      wr(2'd1, 8'd3); wr(2'd0, 8'h02);
      measure(n); @(negedge clk);
      chk("R9 masked irq", irq, 0);
      wr(2'd0, 8'h01);
      chk("R9 pending exposed", irq, 1);
      rd(2'd1, v);
      chk("R10 other read keeps", irq, 1);
      rd(2'd0, v);
      chk("R10 ctrl value", v, 8'h01);
      chk("R10 cleared", irq, 0);
      wr(2'd0, 8'h03);
      measure(n); @(negedge clk);
      chk("R9 enabled irq", irq, 1);
      rd(2'd0, v); chk("R10 cleared again", irq, 0);

      // R11 alternate tick source
      wr(2'd0, 8'h0A);
      snap = tc_cnt;
      repeat (30) @(negedge clk);
      chk("R11 sysclk ignored", tc_cnt, snap);
      alt_pulse(1);
      alt_pulse(10);
      chk("R11 held level once", tc_cnt, snap);
      alt_pulse(1);
      chk("R11 third edge", tc_cnt, snap + 1);
      rd(2'd0, v); chk("R11 single halts", v, 8'h08);

      summary();
      $finish;
   end

endmodule